// File: doc/BRIEF.md
# Interrupt Pending and Wake Decision Unit

This block sits in the system-control unit of a RISC core and makes two decisions on external and software interrupt requests. The first is whether the core should take an interrupt. The second is whether a core parked in its wait state should resume fetching. Each line counts as pending when its request bit in the cause register and its own mask bit in the status register are both set. Interrupts are globally enabled only when the global enable bit is set and no condition blocks them: exception level, error level, debug mode or the per-thread exempt flag.

The two decisions are kept apart. The take request needs a line that is both pending and enabled, and it comes out one clock later from a register. The wake request is a level that is raised only while the core reports that it is halted. A configuration strap for the newer architecture release lets any pending, unmasked line wake the core even while interrupts are globally disabled. The core then resumes without taking the interrupt.

Top module: `irq_wake_ctrl`

## Requirements
- R1: Interrupts count as enabled only when `ie_i`=1, `exl_i`=0, `erl_i`=0, `dbg_mode_i`=0 and `thread_exempt_i`=0. If any one of these conditions fails, `take_o` stays 0 even with a line pending.
- R2: A line is pending when `irq_pend_i` AND `irq_mask_i` is nonzero in any bit position.
- R3: Each line is gated only by the mask bit at its own index. A request bit whose own mask bit is 0 causes no take and no wake, even when other mask bits are set.
- R4: `take_o` is a register. After each rising clock edge it equals (enabled AND pending) as sampled at that edge.
- R5: While `rst_ni` is low, `take_o` is 0.
- R6: With `r6_wake_i`=1, `wake_o` = `halted_i` AND pending, whatever the enable state.
- R7: With `r6_wake_i`=0, `wake_o` = `halted_i` AND pending AND enabled.
- R8: `wake_o` is 0 whenever `halted_i` is 0.
- R9: The two software lines (bits 0 and 1) and the six hardware lines (bits 2 to 7) are treated identically.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ie_i | input | 1 | Global interrupt enable bit of the status register |
| exl_i | input | 1 | Exception-level bit of the status register |
| erl_i | input | 1 | Error-level bit of the status register |
| irq_mask_i | input | NUM_LINES | Per-line mask bits of the status register |
| irq_pend_i | input | NUM_LINES | Per-line request bits of the cause register |
| dbg_mode_i | input | 1 | Core is in debug mode |
| thread_exempt_i | input | 1 | Active thread is exempt from interrupts |
| r6_wake_i | input | 1 | Strap: a masked-enabled pending line wakes the core while interrupts are disabled |
| halted_i | input | 1 | Core is in its wait state |
| wake_o | output | 1 | Level request to leave the wait state |
| take_o | output | 1 | Registered request to take an interrupt |

## Verification
The assertions assume that all inputs are synchronous to `clk_i` and change only after a rising edge. They also assume the strap and the status fields carry no unknown values once reset is released. The bench changes every input one nanosecond after the rising edge and compares the outputs at the falling edge, so each sampled value is stable around the edge. Directed cases block one enable condition at a time and try each line on its own, and a seeded random phase then covers mixed mask, strap and halt patterns.

// File: rtl/irq_wake_pkg.sv
package irq_wake_pkg;
  localparam int unsigned IRQ_LINES_DEF = 8;
  localparam int unsigned IRQ_SW_LINES  = 2;

  typedef struct packed {
    logic ie;
    logic exl;
    logic erl;
  } status_ctl_t;

  typedef struct packed {
    logic dbg_mode;
    logic thread_exempt;
  } block_ctl_t;
endpackage

// File: rtl/irq_line_match.sv
module irq_line_match #(
  parameter int unsigned NUM_LINES = 8
) (
  input  logic [NUM_LINES-1:0] pend_i,
  input  logic [NUM_LINES-1:0] mask_i,
  output logic                 any_hit_o
);
  logic [NUM_LINES-1:0] hit;

  // one independent gate per line; no priority between lines
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    assign hit[g] = pend_i[g] & mask_i[g];
  end

  assign any_hit_o = |hit;
endmodule

// File: rtl/irq_gate_enable.sv
module irq_gate_enable
  import irq_wake_pkg::*;
(
  input  status_ctl_t st_i,
  input  block_ctl_t  blk_i,
  output logic        enabled_o
);
  logic blocked;

  always_comb begin
    blocked   = st_i.exl | st_i.erl | blk_i.dbg_mode | blk_i.thread_exempt;
    enabled_o = st_i.ie & ~blocked;
  end
endmodule

// File: rtl/irq_wake_take.sv
module irq_wake_take (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enabled_i,
  input  logic pending_i,
  input  logic r6_wake_i,
  input  logic halted_i,
  output logic wake_o,
  output logic take_o
);
  logic take_q;
  logic wake_qual;

  // strap lets a disabled-but-pending line restart fetch without a take
  assign wake_qual = pending_i & (enabled_i | r6_wake_i);
  assign wake_o    = halted_i & wake_qual;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) take_q <= 1'b0;
    else         take_q <= enabled_i & pending_i;
  end

  assign take_o = take_q;
endmodule

// File: rtl/irq_wake_ctrl.sv
module irq_wake_ctrl
  import irq_wake_pkg::*;
#(
  parameter int unsigned NUM_LINES = IRQ_LINES_DEF
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ie_i,
  input  logic                 exl_i,
  input  logic                 erl_i,
  input  logic [NUM_LINES-1:0] irq_mask_i,
  input  logic [NUM_LINES-1:0] irq_pend_i,
  input  logic                 dbg_mode_i,
  input  logic                 thread_exempt_i,
  input  logic                 r6_wake_i,
  input  logic                 halted_i,
  output logic                 wake_o,
  output logic                 take_o
);
  status_ctl_t st;
  block_ctl_t  blk;
  logic        enabled;
  logic        pending;

  assign st  = '{ie: ie_i, exl: exl_i, erl: erl_i};
  assign blk = '{dbg_mode: dbg_mode_i, thread_exempt: thread_exempt_i};

  irq_line_match #(.NUM_LINES(NUM_LINES)) i_match (
    .pend_i    (irq_pend_i),
    .mask_i    (irq_mask_i),
    .any_hit_o (pending)
  );

  irq_gate_enable i_gate (
    .st_i      (st),
    .blk_i     (blk),
    .enabled_o (enabled)
  );

  irq_wake_take i_decide (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .enabled_i (enabled),
    .pending_i (pending),
    .r6_wake_i (r6_wake_i),
    .halted_i  (halted_i),
    .wake_o    (wake_o),
    .take_o    (take_o)
  );
endmodule

// File: rtl/irq_wake_ctrl_chk.sv
module irq_wake_ctrl_chk #(
  parameter int unsigned NUM_LINES = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 ie_i,
  input logic                 exl_i,
  input logic                 erl_i,
  input logic [NUM_LINES-1:0] irq_mask_i,
  input logic [NUM_LINES-1:0] irq_pend_i,
  input logic                 dbg_mode_i,
  input logic                 thread_exempt_i,
  input logic                 r6_wake_i,
  input logic                 halted_i,
  input logic                 wake_o,
  input logic                 take_o
);
  logic en_ok, pend_ok;
  assign en_ok   = ie_i && !exl_i && !erl_i && !dbg_mode_i && !thread_exempt_i;
  assign pend_ok = (irq_pend_i & irq_mask_i) != '0;

  assert_take_follows_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_ok && pend_ok) |=> take_o);

  assert_no_take_when_blocked_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_ok |=> !take_o);

  assert_no_take_unmasked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_ok |=> !take_o);

  assert_reset_clear_R5: assert property (@(posedge clk_i)
    !rst_ni |-> !take_o);

  assert_wake_needs_halt_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> halted_i);

  assert_wake_needs_pending_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> pend_ok);

  assert_wake_strict_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_o && !r6_wake_i) |-> en_ok);

  assert_wake_strap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r6_wake_i && halted_i && pend_ok) |-> wake_o);
endmodule

bind irq_wake_ctrl irq_wake_ctrl_chk #(.NUM_LINES(NUM_LINES)) i_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .ie_i            (ie_i),
  .exl_i           (exl_i),
  .erl_i           (erl_i),
  .irq_mask_i      (irq_mask_i),
  .irq_pend_i      (irq_pend_i),
  .dbg_mode_i      (dbg_mode_i),
  .thread_exempt_i (thread_exempt_i),
  .r6_wake_i       (r6_wake_i),
  .halted_i        (halted_i),
  .wake_o          (wake_o),
  .take_o          (take_o)
);

// File: tb/test_irq_wake_ctrl.sv
`timescale 1ns/1ps
module test_irq_wake_ctrl;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ie = 0, exl = 0, erl = 0, dbg = 0, exempt = 0, strap = 0, halted = 0;
  logic [N-1:0] mask = '0, pend = '0;
  logic wake, take;

  int checks = 0, failures = 0;
  bit exp_take = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_wake_ctrl #(.NUM_LINES(N)) i_irq_wake_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .ie_i(ie), .exl_i(exl), .erl_i(erl),
    .irq_mask_i(mask), .irq_pend_i(pend), .dbg_mode_i(dbg),
    .thread_exempt_i(exempt), .r6_wake_i(strap), .halted_i(halted),
    .wake_o(wake), .take_o(take)
  );

  function automatic bit m_pending();
    bit p = 0;
    for (int k = 0; k < N; k++) if (pend[k] && mask[k]) p = 1;
    return p;
  endfunction

  function automatic bit m_enabled();
    if (!ie) return 0;
    if (exl || erl || dbg || exempt) return 0;
    return 1;
  endfunction

  function automatic bit m_wake();
    if (!halted || !m_pending()) return 0;
    if (strap) return 1;
    return m_enabled();
  endfunction

  task automatic check(string tag, string what, logic act, bit expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, expv);
    end
  endtask

  // inputs already set; compare at falling edge, then advance one clock
  task automatic step(string tag_take, string tag_wake);
    @(negedge clk);
    check(tag_take, "take_o", take, exp_take);
    check(tag_wake, "wake_o", wake, m_wake());
    @(posedge clk);
    exp_take = rst_n ? (m_enabled() && m_pending()) : 1'b0;
    #1;
  endtask

  task automatic set_all(bit ie_v, bit exl_v, bit erl_v, bit dbg_v, bit ex_v,
                         bit st_v, bit h_v, logic [N-1:0] m_v, logic [N-1:0] p_v);
    ie = ie_v; exl = exl_v; erl = erl_v; dbg = dbg_v; exempt = ex_v;
    strap = st_v; halted = h_v; mask = m_v; pend = p_v;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R5: reset holds take low even with an enabled pending line
    set_all(1, 0, 0, 0, 0, 0, 0, 8'hFF, 8'hFF);
    repeat (3) step("R5", "R7");
    @(negedge clk);
    check("R5", "take_o in reset", take, 1'b0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    exp_take = m_enabled() && m_pending();

    // R4: registered take
    set_all(1, 0, 0, 0, 0, 0, 0, 8'h04, 8'h04);
    step("R4", "R8"); step("R4", "R8");
    set_all(1, 0, 0, 0, 0, 0, 0, 8'h04, 8'h00);
    step("R4", "R8"); step("R4", "R8");

    // R1: each blocking condition alone
    for (int c = 0; c < 5; c++) begin
      set_all(c != 0, c == 1, c == 2, c == 3, c == 4, 0, 1, 8'h20, 8'h20);
      step("R1", "R7"); step("R1", "R7");
    end

    // R3: request on a line whose own mask bit is clear
    set_all(1, 0, 0, 0, 0, 1, 1, 8'h7F, 8'h80);
    step("R3", "R3"); step("R3", "R3");
    set_all(1, 0, 0, 0, 0, 1, 1, 8'hFE, 8'h01);
    step("R3", "R3"); step("R3", "R3");

    // R9: every line alone, software and hardware
    for (int k = 0; k < N; k++) begin
      set_all(1, 0, 0, 0, 0, 0, 1, 8'(1 << k), 8'(1 << k));
      step("R9", "R9"); step("R9", "R9");
    end

    // R6: strap wakes a halted core while disabled, no take
    set_all(0, 1, 0, 0, 0, 1, 1, 8'h08, 8'h08);
    step("R6", "R6"); step("R6", "R6");
    // R7: same without strap, no wake
    set_all(0, 1, 0, 0, 0, 0, 1, 8'h08, 8'h08);
    step("R7", "R7"); step("R7", "R7");
    // R8: not halted, strap and pending: no wake
    set_all(1, 0, 0, 0, 0, 1, 0, 8'hFF, 8'hFF);
    step("R4", "R8"); step("R4", "R8");

    // R2: random mixes
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r = $urandom;
      set_all(r[0] | r[1], r[2] & r[3], r[4] & r[5], r[6] & r[7], r[8] & r[9],
              r[10], r[11] | r[12], r[23:16], r[31:24]);
      step("R2", strap ? "R6" : "R7");
    end

    // R5: asynchronous reset mid-run
    set_all(1, 0, 0, 0, 0, 0, 0, 8'hFF, 8'hFF);
    step("R4", "R8");
    rst_n = 1'b0; #1;
    check("R5", "take_o after reset", take, 1'b0);
    exp_take = 0;
    step("R5", "R8");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule